// File: doc/BRIEF.md
# Event-Driven Multi-Output PWM Timer

This block is a general-purpose timer in which pulse-width channels are not fixed hardware. One up-counter, advanced by a programmable prescaler, is compared against a bank of match registers. A set of events watches those comparisons. Each event picks one match register and fires on every count step where the counter equals it. Each output has a set mask and a clear mask with one bit per event. Together they decide which events drive that output high and which drive it low. A per-output rule settles the case where both happen on the same step. A limit mask names the events that send the counter back to zero, and this is how the period is formed.

Software configures everything through a single-cycle word-addressed register bus. Writes take effect at the next clock edge, and reads return data in the same cycle. Each match register has a reload shadow that is copied in whenever the counter wraps on a limit event. New duty values therefore land only at period boundaries and produce no glitches.

A typical PWM setup uses one event as the period event. It matches P-1, sits in the limit mask and sets the output. A second event matches D and clears the output. The conflict rule is "set". For inverted polarity the set and clear roles swap, and the conflict rule becomes "clear".

Top module: `evpwm_timer`

## Requirements
- R1: After reset every output is 0, and every register reads back as 0.
- R2: When the halt bit (CTRL word 0x01, bit 2) is 0, the counter advances by one every PRE+1 clocks. PRE is the field at CTRL bits 5 upward, PRE_W bits wide.
- R3: When the halt bit is 1, the counter and the prescaler are frozen. The counter is readable and writable at word 0x04, and a write there loads the counter directly.
- R4: CTRL bit 4 (count direction) always reads 0 and has no effect: the counter keeps counting up.
- R5: Event e is configured at word 0x80+e. It fires on a count step when bit 12 of that word is 1 and the counter equals the match register selected by the word's low bits. When bit 12 is 0, the event never fires.
- R6: The limit mask is at word 0x02, with bit e standing for event e. On a count step where any masked event fires, the counter goes to 0 instead of incrementing.
- R7: Output o has a set mask at word 0xA0+o and a clear mask at word 0xC0+o. A firing event named in the set mask drives the output to 1, and one named in the clear mask drives it to 0. The change appears on the clock edge that ends the step. With neither, the output keeps its level.
- R8: The resolve word is at 0x03, with bits 2o+1:2o serving output o. When an output is set and cleared on the same step, it applies code 0 (keep), 1 (to 1), 2 (to 0) or 3 (invert).
- R9: Match register i is at word 0x40+i, and its reload shadow is at 0x60+i. On every limit wrap, each match register copies its shadow, unless the no-reload bit (CFG word 0x00, bit 7) is 1. CFG bit 0 is stored and read back.
- R10: Take a period event matching P-1 that is in the limit mask and sets the output, and a duty event matching D that clears it, with rule 1. With PRE=0, the output is high for D+1 of every P clocks when D < P-1, and always high when D ≥ P-1. The inverted arrangement (roles swapped, rule 2) is high for the remaining P minus that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 8 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| pwm_out | output | N_OUT | Registered outputs |

## Verification
The bench builds the block with four events, four outputs, an 8-bit counter and a 4-bit prescaler. At that size the whole duty range from 0 to P can be swept for several periods. The normal and inverted outputs are compared against the arithmetic D+1 rule, including the two coincident cases at D = P-1 and D = P. The small counter also lets the prescaler, the halt bit, the wrap-time reload with and without the no-reload bit, and the keep and invert conflict codes each be reached within a few dozen cycles.

// File: rtl/evpwm_pkg.sv
package evpwm_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 8;

    // single registers (section 0)
    localparam logic [ADDR_W-1:0] A_CFG     = 8'h00;
    localparam logic [ADDR_W-1:0] A_CTRL    = 8'h01;
    localparam logic [ADDR_W-1:0] A_LIMIT   = 8'h02;
    localparam logic [ADDR_W-1:0] A_RESOLVE = 8'h03;
    localparam logic [ADDR_W-1:0] A_COUNT   = 8'h04;

    // indexed sections: addr[7:5] selects, addr[4:0] indexes
    localparam logic [2:0] SEC_GLOBAL = 3'd0;
    localparam logic [2:0] SEC_MATCH  = 3'd2;
    localparam logic [2:0] SEC_RELOAD = 3'd3;
    localparam logic [2:0] SEC_EVCTL  = 3'd4;
    localparam logic [2:0] SEC_SETM   = 3'd5;
    localparam logic [2:0] SEC_CLRM   = 3'd6;

    localparam int CFG_UNIFY_BIT = 0;
    localparam int CFG_NORL_BIT  = 7;
    localparam int CTRL_HALT_BIT = 2;
    localparam int CTRL_PRE_LSB  = 5;
    localparam int EVC_COMB_BIT  = 12;

    typedef enum logic [1:0] {
        RES_KEEP = 2'd0,
        RES_SET  = 2'd1,
        RES_CLR  = 2'd2,
        RES_TOG  = 2'd3
    } res_e;

    function automatic logic next_level(logic cur, logic s_hit, logic c_hit, res_e rule);
        logic nxt;
        if (s_hit && c_hit) begin
            case (rule)
                RES_SET: nxt = 1'b1;
                RES_CLR: nxt = 1'b0;
                RES_TOG: nxt = ~cur;
                default: nxt = cur;
            endcase
        end else if (s_hit) begin
            nxt = 1'b1;
        end else if (c_hit) begin
            nxt = 1'b0;
        end else begin
            nxt = cur;
        end
        return nxt;
    endfunction

endpackage

// File: rtl/evpwm_regs.sv
module evpwm_regs
    import evpwm_pkg::*;
#(
    parameter int N_EV  = 16,
    parameter int N_OUT = 16,
    parameter int CNT_W = 32,
    parameter int PRE_W = 8,
    localparam int SEL_W = $clog2(N_EV),
    localparam int OSEL_W = $clog2(N_OUT)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_we,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic                 wrap,
    input  logic [CNT_W-1:0]     cnt_val,
    output logic                 cnt_wr,
    output logic [CNT_W-1:0]     cnt_wdata,
    output logic                 halt_q,
    output logic [PRE_W-1:0]     pre_q,
    output logic [N_EV-1:0]      limit_q,
    output logic [2*N_OUT-1:0]   res_q,
    output logic [CNT_W-1:0]     match_q [N_EV],
    output logic [SEL_W-1:0]     evsel_q [N_EV],
    output logic [N_EV-1:0]      evcomb_q,
    output logic [N_EV-1:0]      setm_q [N_OUT],
    output logic [N_EV-1:0]      clrm_q [N_OUT]
);

    logic [2:0]        sec;
    logic [4:0]        idx;
    logic [SEL_W-1:0]  idx_e;
    logic [OSEL_W-1:0] idx_o;
    logic              unify_q;
    logic              norl_q;
    logic [CNT_W-1:0]  reload_q [N_EV];

    assign sec       = bus_addr[7:5];
    assign idx       = bus_addr[4:0];
    assign idx_e     = idx[SEL_W-1:0];
    assign idx_o     = idx[OSEL_W-1:0];
    assign cnt_wr    = bus_we && (bus_addr == A_COUNT);
    assign cnt_wdata = bus_wdata[CNT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            unify_q  <= 1'b0;
            norl_q   <= 1'b0;
            halt_q   <= 1'b0;
            pre_q    <= '0;
            limit_q  <= '0;
            res_q    <= '0;
            evcomb_q <= '0;
            for (int i = 0; i < N_EV; i++) begin
                match_q[i]  <= '0;
                reload_q[i] <= '0;
                evsel_q[i]  <= '0;
            end
            for (int o = 0; o < N_OUT; o++) begin
                setm_q[o] <= '0;
                clrm_q[o] <= '0;
            end
        end else begin
            if (bus_we && bus_addr == A_CFG) begin
                unify_q <= bus_wdata[CFG_UNIFY_BIT];
                norl_q  <= bus_wdata[CFG_NORL_BIT];
            end
            if (bus_we && bus_addr == A_CTRL) begin
                halt_q <= bus_wdata[CTRL_HALT_BIT];
                pre_q  <= bus_wdata[CTRL_PRE_LSB +: PRE_W];
            end
            if (bus_we && bus_addr == A_LIMIT)
                limit_q <= bus_wdata[N_EV-1:0];
            if (bus_we && bus_addr == A_RESOLVE)
                res_q <= bus_wdata[2*N_OUT-1:0];
            for (int i = 0; i < N_EV; i++) begin
                if (bus_we && sec == SEC_MATCH && idx == 5'(i))
                    match_q[i] <= bus_wdata[CNT_W-1:0];
                else if (wrap && !norl_q)
                    match_q[i] <= reload_q[i];
                if (bus_we && sec == SEC_RELOAD && idx == 5'(i))
                    reload_q[i] <= bus_wdata[CNT_W-1:0];
                if (bus_we && sec == SEC_EVCTL && idx == 5'(i)) begin
                    evsel_q[i]  <= bus_wdata[SEL_W-1:0];
                    evcomb_q[i] <= bus_wdata[EVC_COMB_BIT];
                end
            end
            for (int o = 0; o < N_OUT; o++) begin
                if (bus_we && sec == SEC_SETM && idx == 5'(o))
                    setm_q[o] <= bus_wdata[N_EV-1:0];
                if (bus_we && sec == SEC_CLRM && idx == 5'(o))
                    clrm_q[o] <= bus_wdata[N_EV-1:0];
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sec)
            SEC_GLOBAL: begin
                case (bus_addr)
                    A_CFG: begin
                        bus_rdata[CFG_UNIFY_BIT] = unify_q;
                        bus_rdata[CFG_NORL_BIT]  = norl_q;
                    end
                    A_CTRL: begin
                        bus_rdata[CTRL_HALT_BIT]          = halt_q;
                        bus_rdata[CTRL_PRE_LSB +: PRE_W]  = pre_q;
                    end
                    A_LIMIT:   bus_rdata[N_EV-1:0]    = limit_q;
                    A_RESOLVE: bus_rdata[2*N_OUT-1:0] = res_q;
                    A_COUNT:   bus_rdata[CNT_W-1:0]   = cnt_val;
                    default:   bus_rdata = '0;
                endcase
            end
            SEC_MATCH:  if (int'(idx) < N_EV) bus_rdata[CNT_W-1:0] = match_q[idx_e];
            SEC_RELOAD: if (int'(idx) < N_EV) bus_rdata[CNT_W-1:0] = reload_q[idx_e];
            SEC_EVCTL: begin
                if (int'(idx) < N_EV) begin
                    bus_rdata[SEL_W-1:0]    = evsel_q[idx_e];
                    bus_rdata[EVC_COMB_BIT] = evcomb_q[idx_e];
                end
            end
            SEC_SETM: if (int'(idx) < N_OUT) bus_rdata[N_EV-1:0] = setm_q[idx_o];
            SEC_CLRM: if (int'(idx) < N_OUT) bus_rdata[N_EV-1:0] = clrm_q[idx_o];
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/evpwm_counter.sv
module evpwm_counter #(
    parameter int CNT_W = 32,
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             halt,
    input  logic [PRE_W-1:0] pre,
    input  logic             limit_hit,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             tick
);

    logic [PRE_W-1:0] pcnt_q;

    // a count step happens when the prescaler has served PRE+1 clocks
    assign tick = !halt && (pcnt_q >= pre);

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (halt || tick)
                pcnt_q <= '0;
            else
                pcnt_q <= pcnt_q + 1'b1;

            if (cnt_wr)
                cnt_q <= cnt_wdata;
            else if (tick)
                cnt_q <= limit_hit ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/evpwm_events.sv
module evpwm_events #(
    parameter int N_EV  = 16,
    parameter int CNT_W = 32,
    localparam int SEL_W = $clog2(N_EV)
) (
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] match_q [N_EV],
    input  logic [SEL_W-1:0] evsel_q [N_EV],
    input  logic [N_EV-1:0]  evcomb_q,
    output logic [N_EV-1:0]  fire
);

    for (genvar e = 0; e < N_EV; e++) begin : g_ev
        logic sel_ok;
        assign sel_ok  = int'(evsel_q[e]) < N_EV;
        assign fire[e] = tick && evcomb_q[e] && sel_ok && (cnt == match_q[evsel_q[e]]);
    end

endmodule

// File: rtl/evpwm_outputs.sv
module evpwm_outputs
    import evpwm_pkg::*;
#(
    parameter int N_EV  = 16,
    parameter int N_OUT = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [N_EV-1:0]    fire,
    input  logic [N_EV-1:0]    setm_q [N_OUT],
    input  logic [N_EV-1:0]    clrm_q [N_OUT],
    input  logic [2*N_OUT-1:0] res_q,
    output logic [N_OUT-1:0]   pwm_q
);

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        logic s_hit, c_hit, lvl_q;
        assign s_hit = |(fire & setm_q[o]);
        assign c_hit = |(fire & clrm_q[o]);

        always_ff @(posedge clk) begin
            if (rst)
                lvl_q <= 1'b0;
            else
                lvl_q <= next_level(lvl_q, s_hit, c_hit, res_e'(res_q[2*o +: 2]));
        end

        assign pwm_q[o] = lvl_q;
    end

endmodule

// File: rtl/evpwm_timer.sv
module evpwm_timer
    import evpwm_pkg::*;
#(
    parameter int N_EV  = 16,
    parameter int N_OUT = 16,
    parameter int CNT_W = 32,
    parameter int PRE_W = 8,
    localparam int SEL_W = $clog2(N_EV)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [N_OUT-1:0]  pwm_out
);

    logic               tick_w, limit_hit_w, wrap_w, cnt_wr_w, halt_w;
    logic [CNT_W-1:0]   cnt_w, cnt_wdata_w;
    logic [PRE_W-1:0]   pre_w;
    logic [N_EV-1:0]    limit_w, evcomb_w, fire_w;
    logic [2*N_OUT-1:0] res_w;
    logic [CNT_W-1:0]   match_w [N_EV];
    logic [SEL_W-1:0]   evsel_w [N_EV];
    logic [N_EV-1:0]    setm_w [N_OUT];
    logic [N_EV-1:0]    clrm_w [N_OUT];

    assign limit_hit_w = |(fire_w & limit_w);
    assign wrap_w      = tick_w && limit_hit_w;

    evpwm_regs #(.N_EV(N_EV), .N_OUT(N_OUT), .CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wrap(wrap_w), .cnt_val(cnt_w), .cnt_wr(cnt_wr_w), .cnt_wdata(cnt_wdata_w),
        .halt_q(halt_w), .pre_q(pre_w), .limit_q(limit_w), .res_q(res_w),
        .match_q(match_w), .evsel_q(evsel_w), .evcomb_q(evcomb_w),
        .setm_q(setm_w), .clrm_q(clrm_w)
    );

    evpwm_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_cnt (
        .clk(clk), .rst(rst), .halt(halt_w), .pre(pre_w), .limit_hit(limit_hit_w),
        .cnt_wr(cnt_wr_w), .cnt_wdata(cnt_wdata_w), .cnt_q(cnt_w), .tick(tick_w)
    );

    evpwm_events #(.N_EV(N_EV), .CNT_W(CNT_W)) u_ev (
        .tick(tick_w), .cnt(cnt_w), .match_q(match_w), .evsel_q(evsel_w),
        .evcomb_q(evcomb_w), .fire(fire_w)
    );

    evpwm_outputs #(.N_EV(N_EV), .N_OUT(N_OUT)) u_out (
        .clk(clk), .rst(rst), .fire(fire_w), .setm_q(setm_w), .clrm_q(clrm_w),
        .res_q(res_w), .pwm_q(pwm_out)
    );

endmodule

// File: rtl/evpwm_timer_chk.sv
module evpwm_timer_chk #(
    parameter int CNT_W = 32,
    parameter int N_OUT = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             limit_hit,
    input logic             halt,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt,
    input logic [N_OUT-1:0] pwm_out
);

    assert_frozen_when_halted_R3: assert property (@(posedge clk) disable iff (rst)
        (halt && !cnt_wr) |=> $stable(cnt));

    assert_step_by_one_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && !limit_hit && !cnt_wr) |=> (cnt == $past(cnt) + CNT_W'(1)));

    assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (tick && limit_hit && !cnt_wr) |=> (cnt == '0));

    assert_out_moves_on_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(pwm_out) |-> $past(tick));

endmodule

bind evpwm_timer evpwm_timer_chk #(.CNT_W(CNT_W), .N_OUT(N_OUT)) u_chk (
    .clk(clk), .rst(rst), .tick(tick_w), .limit_hit(limit_hit_w), .halt(halt_w),
    .cnt_wr(cnt_wr_w), .cnt(cnt_w), .pwm_out(pwm_out)
);

// File: tb/evpwm_timer_test.sv
module evpwm_timer_test;

    localparam int N_EV  = 4;
    localparam int N_OUT = 4;
    localparam int CNT_W = 8;
    localparam int PRE_W = 4;

    localparam logic [7:0] A_CFG = 8'h00, A_CTRL = 8'h01, A_LIMIT = 8'h02,
                           A_RES = 8'h03, A_CNT = 8'h04;
    localparam logic [7:0] B_MATCH = 8'h40, B_RELOAD = 8'h60, B_EVC = 8'h80,
                           B_SET = 8'hA0, B_CLR = 8'hC0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_we = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [N_OUT-1:0]  pwm_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evpwm_timer #(.N_EV(N_EV), .N_OUT(N_OUT), .CNT_W(CNT_W), .PRE_W(PRE_W)) uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int d);
        bus_addr = a;
        #1;
        d = int'(bus_rdata);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R10: period P, duty D; outputs 0 (normal), 1 (inverted), 2 (toggle), 3 (keep)
    task automatic pwm_case(input int p, input int d);
        int hi [N_OUT];
        int h;
        wr(A_CTRL, 32'h4);
        wr(B_MATCH + 8'd0, 32'(p - 1));
        wr(B_RELOAD + 8'd0, 32'(p - 1));
        wr(B_MATCH + 8'd1, 32'(d));
        wr(B_RELOAD + 8'd1, 32'(d));
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'h0);
        idle(3 * p + 2);
        for (int k = 0; k < N_OUT; k++) hi[k] = 0;
        for (int c = 0; c < 2 * p; c++) begin
            @(negedge clk);
            for (int k = 0; k < N_OUT; k++) hi[k] += int'(pwm_out[k]);
        end
        h = (d >= p - 1) ? p : d + 1;
        chk($sformatf("R10 normal P=%0d D=%0d", p, d), hi[0], 2 * h);
        chk($sformatf("R10 inverted P=%0d D=%0d", p, d), hi[1], 2 * (p - h));
        if (d == 0) begin
            chk($sformatf("R8 invert rule P=%0d", p), hi[2], p);
            chk($sformatf("R8 keep rule P=%0d", p), hi[3], 0);
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int v, v2;
        idle(5);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        chk("R1 outputs", int'(pwm_out), 0);
        rd(A_CTRL, v);       chk("R1 ctrl", v, 0);
        rd(A_LIMIT, v);      chk("R1 limit", v, 0);
        rd(B_MATCH + 8'd2, v); chk("R1 match2", v, 0);
        rd(A_RES, v);        chk("R1 resolve", v, 0);

        // static wiring for the PWM sweep
        wr(B_EVC + 8'd0, 32'h1000);          // event0 -> match0
        wr(B_EVC + 8'd1, 32'h1001);          // event1 -> match1
        wr(A_LIMIT, 32'h1);
        wr(B_SET + 8'd0, 32'h1); wr(B_CLR + 8'd0, 32'h2);
        wr(B_SET + 8'd1, 32'h2); wr(B_CLR + 8'd1, 32'h1);
        wr(B_SET + 8'd2, 32'h1); wr(B_CLR + 8'd2, 32'h1);
        wr(B_SET + 8'd3, 32'h1); wr(B_CLR + 8'd3, 32'h1);
        wr(A_RES, 32'd57);                    // out0=1 out1=2 out2=3 out3=0
        rd(A_RES, v); chk("R8 resolve readback", v, 57);

        for (int p = 3; p <= 5; p += 2)
            for (int d = 0; d <= p; d++)
                pwm_case(p, d);
        pwm_case(8, 4);

        // R9 reload on wrap
        pwm_case(6, 1);
        wr(A_CTRL, 32'h4);
        wr(A_CNT, 32'h0);
        wr(B_RELOAD + 8'd1, 32'd4);
        wr(A_CTRL, 32'h0);
        rd(B_MATCH + 8'd1, v); chk("R9 match before wrap", v, 1);
        idle(8);
        rd(B_MATCH + 8'd1, v); chk("R9 match after wrap", v, 4);
        wr(A_CFG, 32'h81);
        rd(A_CFG, v); chk("R9 cfg readback", v, 32'h81);
        wr(B_RELOAD + 8'd1, 32'd2);
        idle(14);
        rd(B_MATCH + 8'd1, v); chk("R9 no-reload holds match", v, 4);
        wr(A_CFG, 32'h0);

        // R2 prescaler, no limit
        wr(A_CTRL, 32'h4);
        wr(A_LIMIT, 32'h0);
        wr(A_CNT, 32'h0);
        wr(A_CTRL, 32'(2 << 5));
        idle(9);
        rd(A_CNT, v); chk("R2 prescale after 9 clocks", v, 3);
        idle(3);
        rd(A_CNT, v); chk("R2 prescale after 12 clocks", v, 4);

        // R3 halt freezes, count writable
        wr(A_CTRL, 32'h4);
        wr(A_CNT, 32'd77);
        rd(A_CNT, v);
        idle(10);
        rd(A_CNT, v2);
        chk("R3 count write", v, 77);
        chk("R3 halted count stable", v2, 77);

        // R4 direction bit ignored
        wr(A_CTRL, 32'h10);
        rd(A_CTRL, v); chk("R4 direction reads 0", v, 0);
        wr(A_CNT, 32'h0);
        idle(5);
        rd(A_CNT, v); chk("R4 still counts up", v, 5);

        // R5/R6 event without match mode never fires, so no wrap
        wr(A_LIMIT, 32'h1);
        wr(B_EVC + 8'd0, 32'h0000);
        wr(A_CNT, 32'h0);
        idle(20);
        rd(A_CNT, v); chk("R5 disabled event does not wrap", v, 20);
        wr(B_EVC + 8'd0, 32'h1000);
        wr(A_CNT, 32'h0);
        idle(20);
        rd(A_CNT, v); chk("R6 limit wrap period 6", v, 20 % 6);

        // R7 empty masks keep level
        wr(B_SET + 8'd0, 32'h0); wr(B_CLR + 8'd0, 32'h0);
        v = int'(pwm_out[0]);
        idle(13);
        chk("R7 empty masks hold", int'(pwm_out[0]), v);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule